// File: doc/BRIEF.md
# Buffered-Reload Motor PWM Generator

This block produces one edge-aligned PWM output for motor drive. A free-running counter, advanced by a programmable prescaler, counts from zero up to one below the modulus. The output is high while the count is below the duty value. Software writes the prescaler, modulus and duty into shadow registers. These reach the active registers only at a controlled reload point, so every PWM period is built from a single consistent set of values.

A reload point is the end of a load cycle of 1, 2, 4 or 8 PWM periods. Software arms a load with a self-clearing load-permit flag. The flag can be withdrawn by writing it back to zero before the reload point arrives. A one-cycle reload interrupt is raised at each reload point whether or not anything was loaded. A correction-select bit is sampled at the start of every period. When the generator is disabled the counters stop and the output enable falls, unless an output override holds the pins driven.

Top module: `mpwm_gen`

## Requirements
- R1: Writes to address 2 (modulus) and address 3 (duty) go to shadow registers. The active values change only at a reload point while the load permit is set, or when the generator is started with the permit set. A period is therefore never built from mixed settings.
- R2: When the load permit is 0 at a reload point, nothing new is loaded. Writing 0 to the permit (bit 1 of address 0) before the reload point withdraws a pending load.
- R3: The load permit is cleared by reset and cleared by hardware once a load has taken place. Its state is visible on `load_ok_o`.
- R4: `reload_irq` pulses for one cycle at every reload point, in the first cycle of the new period, even when no load takes place.
- R5: The reload rate field (address 1, bits 1:0; values 0,1,2,3) selects a reload every 1, 2, 4 or 8 periods. A change takes effect only after the load cycle in progress ends. The period count restarts whenever the generator is enabled.
- R6: The prescaler field (address 1, bits 3:2; values 0,1,2,3) divides the clock by 1, 2, 4 or 8. It takes effect only through a permitted load, and the divider restarts on each load.
- R7: The count runs from 0 to modulus-1. A period lasts modulus×divide cycles, and the output is high for min(duty, modulus)×divide cycles of it.
- R8: A duty of 0 holds the output low for the whole period. A duty at or above the modulus holds it high for the whole period.
- R9: The correction-select bit (address 1, bit 4) is sampled into `corr_o` only at the start of each period.
- R10: Address 0, bit 0 enables the generator. While it is clear, the counters stop, `pwm_o` is 0, no reload interrupt occurs and `pwm_oe` is 0, unless the override bit (address 0, bit 2) is set, which keeps `pwm_oe` at 1. While it is set, `pwm_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 config, 2 modulus, 3 duty |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | 1 | PWM output level |
| pwm_oe | output | 1 | PWM pin output enable (0 = high impedance) |
| reload_irq | output | 1 | One-cycle pulse at each reload point |
| load_ok_o | output | 1 | Current state of the load permit |
| corr_o | output | 1 | Correction select in force for the current period |

## Verification
The bench builds the block with an 8-bit counter and the default 2-bit select fields. This keeps periods to a few dozen cycles while still covering every prescaler divide and every reload rate up to eight periods per load. It also allows a duty value far above the modulus. Each measured interval between reload interrupts is checked against its period length and high time, and that includes the interval that straddles a pending load, a withdrawn load or a rate change.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_CFG  = 2'd1,
      REG_MOD  = 2'd2,
      REG_DUTY = 2'd3
   } mpwm_reg_e;

   localparam int CTRL_RUN  = 0;
   localparam int CTRL_LDOK = 1;
   localparam int CTRL_OVR  = 2;
endpackage

// File: rtl/mpwm_div.sv
module mpwm_div #(
   parameter int SEL_W   = 2,
   parameter int LOG_MAX = (1 << SEL_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ev,
   input  logic [SEL_W-1:0] sel,
   output logic             hit
);
   localparam int CW = (LOG_MAX < 1) ? 1 : LOG_MAX;

   initial begin
      if (SEL_W < 1) $error("mpwm_div: SEL_W must be at least 1");
   end

   generate
      if (CW == 1) begin : g_toggle
         logic ph;
         assign hit = ev && (sel == '0 || ph);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               ph <= 1'b0;
            else if (clr)             ph <= 1'b0;
            else if (ev && sel != '0) ph <= ~ph;
         end
      end else begin : g_count
         logic [CW-1:0] cnt;
         logic [CW:0]   pow;
         logic [CW-1:0] lim;
         always_comb begin
            pow = (CW+1)'(1) << sel;
            lim = CW'(pow - 1'b1);
         end
         assign hit = ev && (cnt == lim);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (clr) cnt <= '0;
            else if (ev)  cnt <= hit ? '0 : cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/mpwm_count.sv
module mpwm_count #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] modulus,
   input  logic [CNT_W-1:0] duty,
   output logic             period_end,
   output logic             cmp_hi,
   output logic [CNT_W-1:0] cnt_val
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   assign last       = CNT_W'(modulus - 1'b1);
   assign period_end = run && tick && (cnt == last);
   assign cmp_hi     = cnt < duty;
   assign cnt_val    = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (period_end) cnt <= '0;
      else if (tick)       cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/mpwm_gen.sv
module mpwm_gen #(
   parameter int CNT_W = 12,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_o,
   output logic             pwm_oe,
   output logic             reload_irq,
   output logic             load_ok_o,
   output logic             corr_o
);
   import mpwm_pkg::*;

   localparam int RATE_LO  = 0;
   localparam int PRESC_LO = SEL_W;
   localparam int CORR_BIT = 2 * SEL_W;

   initial begin
      if (SEL_W < 1 || SEL_W > 3) $error("mpwm_gen: SEL_W out of range");
      if (CNT_W < CORR_BIT + 1)   $error("mpwm_gen: CNT_W too narrow for config fields");
   end

   logic             run_q, ovr_q, ldok_q, corr_q, irq_q;
   logic [SEL_W-1:0] sh_rate, sh_presc, act_rate, act_presc;
   logic             sh_corr;
   logic [CNT_W-1:0] sh_mod, sh_duty, act_mod, act_duty;

   logic ctrl_wr, start_pt, reload_pt, load_now;
   logic tick, period_end, cmp_hi, rl_hit;
   logic [CNT_W-1:0] cnt_val;

   assign ctrl_wr   = wr_en && (wr_addr == REG_CTRL);
   assign start_pt  = ctrl_wr && wr_data[CTRL_RUN] && !run_q;
   assign reload_pt = run_q && rl_hit;
   assign load_now  = (start_pt && (ldok_q || wr_data[CTRL_LDOK])) ||
                      (reload_pt && ldok_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         ovr_q <= 1'b0;
      end else if (ctrl_wr) begin
         run_q <= wr_data[CTRL_RUN];
         ovr_q <= wr_data[CTRL_OVR];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ldok_q <= 1'b0;
      else if (ctrl_wr)  ldok_q <= wr_data[CTRL_LDOK] && !start_pt;
      else if (load_now) ldok_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_rate  <= '0;
         sh_presc <= '0;
         sh_corr  <= 1'b0;
         sh_mod   <= '0;
         sh_duty  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            REG_CFG: begin
               sh_rate  <= wr_data[RATE_LO +: SEL_W];
               sh_presc <= wr_data[PRESC_LO +: SEL_W];
               sh_corr  <= wr_data[CORR_BIT];
            end
            REG_MOD:  sh_mod  <= wr_data;
            REG_DUTY: sh_duty <= wr_data;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_presc <= '0;
         act_mod   <= '0;
         act_duty  <= '0;
      end else if (load_now) begin
         act_presc <= sh_presc;
         act_mod   <= sh_mod;
         act_duty  <= sh_duty;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       act_rate <= '0;
      else if (start_pt || reload_pt)   act_rate <= sh_rate;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         corr_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= reload_pt;
         if (start_pt || period_end) corr_q <= sh_corr;
      end
   end

   mpwm_div #(.SEL_W(SEL_W)) u_presc (
      .clk(clk), .rst_n(rst_n),
      .clr(!run_q || load_now), .ev(run_q),
      .sel(act_presc), .hit(tick)
   );

   mpwm_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n),
      .run(run_q), .tick(tick),
      .modulus(act_mod), .duty(act_duty),
      .period_end(period_end), .cmp_hi(cmp_hi), .cnt_val(cnt_val)
   );

   mpwm_div #(.SEL_W(SEL_W)) u_reload (
      .clk(clk), .rst_n(rst_n),
      .clr(!run_q), .ev(period_end),
      .sel(act_rate), .hit(rl_hit)
   );

   assign pwm_o      = run_q && cmp_hi;
   assign pwm_oe     = run_q || ovr_q;
   assign reload_irq = irq_q;
   assign load_ok_o  = ldok_q;
   assign corr_o     = corr_q;
endmodule

// File: rtl/mpwm_gen_chk.sv
module mpwm_gen_chk #(
   parameter int CNT_W = 12,
   parameter int SEL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_q,
   input logic             ovr_q,
   input logic             ldok_q,
   input logic             ctrl_wr,
   input logic             start_pt,
   input logic             reload_pt,
   input logic             load_now,
   input logic [SEL_W-1:0] act_rate,
   input logic [CNT_W-1:0] act_mod,
   input logic [CNT_W-1:0] act_duty,
   input logic [CNT_W-1:0] cnt_val,
   input logic             pwm_o,
   input logic             pwm_oe,
   input logic             reload_irq
);
   AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !ovr_q) |-> !pwm_oe);                                  // R10
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !pwm_o);                                               // R10
   AST_MOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_mod) |-> $past(load_now));                           // R1
   AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_duty) |-> $past(load_now));                          // R1
   AST_PERMIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_pt && ldok_q && !ctrl_wr) |=> !ldok_q);                   // R3
   AST_IRQ_NEW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_irq && run_q) |-> (cnt_val == '0));                       // R4
   AST_CNT_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && act_mod != '0) |-> (cnt_val < act_mod));                // R7
   AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_rate) |-> $past(start_pt || reload_pt));             // R5
endmodule

bind mpwm_gen mpwm_gen_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_q(run_q), .ovr_q(ovr_q), .ldok_q(ldok_q),
   .ctrl_wr(ctrl_wr), .start_pt(start_pt), .reload_pt(reload_pt),
   .load_now(load_now), .act_rate(act_rate), .act_mod(act_mod),
   .act_duty(act_duty), .cnt_val(cnt_val), .pwm_o(pwm_o), .pwm_oe(pwm_oe),
   .reload_irq(reload_irq)
);

// File: tb/test_mpwm_gen.sv
module test_mpwm_gen;
   localparam int CNT_W = 8;
   localparam int SEL_W = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_addr = '0;
   logic [CNT_W-1:0] wr_data = '0;
   logic             pwm_o, pwm_oe, reload_irq, load_ok_o, corr_o;

   mpwm_gen #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_mpwm_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_o(pwm_o), .pwm_oe(pwm_oe),
      .reload_irq(reload_irq), .load_ok_o(load_ok_o), .corr_o(corr_o)
   );

   always #2 clk = ~clk;

   typedef struct {
      int    per;
      int    hi;
      string tag;
   } exp_t;

   exp_t  q[$];
   exp_t  e;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    open = 1'b0;
   int    cur_len = 0;
   int    cur_hi = 0;

   // monitor: closes one interval per reload interrupt and compares
   always @(negedge clk) begin
      if (rst_n) begin
         if (reload_irq) begin
            if (open && q.size() > 0) begin
               e = q.pop_front();
               n_chk++;
               if (cur_len != e.per || cur_hi != e.hi) begin
                  n_bad++;
                  $display("FAIL %s interval: actual len=%0d hi=%0d expected len=%0d hi=%0d",
                           e.tag, cur_len, cur_hi, e.per, e.hi);
               end
            end
            open    = 1'b1;
            cur_len = 0;
            cur_hi  = 0;
         end
         if (open) begin
            cur_len++;
            cur_hi += int'(pwm_o);
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = CNT_W'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic sync_irq();
      @(negedge clk);
      while (!reload_irq) @(negedge clk);
      #1;
   endtask

   task automatic push(int n, int per, int hi, string tag);
      for (int i = 0; i < n; i++) q.push_back('{per, hi, tag});
   endtask

   task automatic drain();
      while (q.size() > 0) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      int k;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 reset permit", int'(load_ok_o), 0);
      chk("R10 reset oe", int'(pwm_oe), 0);
      chk("R4 reset irq", int'(reload_irq), 0);

      // start: modulus 10, duty 3, rate/presc 0, permit with enable
      wr(2'd2, 10);
      wr(2'd3, 3);
      wr(2'd1, 'h00);
      wr(2'd0, 'h03);
      chk("R3 permit consumed at start", int'(load_ok_o), 0);
      chk("R10 oe when enabled", int'(pwm_oe), 1);
      sync_irq();
      push(3, 10, 3, "R7");
      drain();

      // R2: new duty without permit is not loaded
      sync_irq();
      wr(2'd3, 7);
      push(3, 10, 3, "R2 no permit");
      drain();

      // R2: permit set then withdrawn before reload
      sync_irq();
      wr(2'd0, 'h03);
      chk("R3 permit visible", int'(load_ok_o), 1);
      wr(2'd0, 'h01);
      chk("R2 permit withdrawn", int'(load_ok_o), 0);
      push(2, 10, 3, "R2 withdrawn");
      drain();

      // R1/R3: modulus 12 with permit; current interval old, then new
      sync_irq();
      wr(2'd2, 12);
      wr(2'd0, 'h03);
      push(1, 10, 3, "R1 old period kept");
      push(3, 12, 7, "R1 new values");
      drain();
      chk("R3 permit cleared by hardware", int'(load_ok_o), 0);

      // R6: prescaler divide 4
      sync_irq();
      wr(2'd1, 'h08);
      wr(2'd0, 'h03);
      push(1, 12, 7, "R6 before load");
      push(3, 48, 28, "R6 divide by 4");
      drain();

      // R5: reload every 2 periods, no permit needed
      sync_irq();
      wr(2'd1, 'h09);
      push(1, 48, 28, "R5 cycle in progress");
      push(3, 96, 56, "R5 every 2nd period");
      drain();
      chk("R4 irq without load keeps permit low", int'(load_ok_o), 0);

      // R8: duty 0, back to rate/presc 0
      sync_irq();
      wr(2'd1, 'h00);
      wr(2'd3, 0);
      wr(2'd0, 'h03);
      push(1, 96, 56, "R5 old rate until end");
      push(3, 12, 0, "R8 duty zero");
      drain();

      // R8: duty above modulus
      sync_irq();
      wr(2'd3, 200);
      wr(2'd0, 'h03);
      push(1, 12, 0, "R8 before load");
      push(3, 12, 12, "R8 duty over modulus");
      drain();

      // R9: correction select sampled at period start
      sync_irq();
      wr(2'd1, 'h10);
      chk("R9 corr unchanged mid-period", int'(corr_o), 0);
      sync_irq();
      chk("R9 corr at period start", int'(corr_o), 1);

      // R5: reload every 8th period
      sync_irq();
      wr(2'd1, 'h13);
      push(1, 12, 12, "R5 before rate change");
      push(2, 96, 96, "R5 every 8th period");
      drain();

      // R10: disable, override, re-enable
      wr(2'd0, 'h00);
      chk("R10 oe off", int'(pwm_oe), 0);
      chk("R10 pwm low", int'(pwm_o), 0);
      n = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (reload_irq) n++;
      end
      chk("R10 no irq while off", n, 0);
      wr(2'd0, 'h04);
      chk("R10 override oe", int'(pwm_oe), 1);
      chk("R10 override pwm low", int'(pwm_o), 0);
      wr(2'd0, 'h01);
      k = 0;
      while (!reload_irq && k < 1000) begin
         @(negedge clk);
         k++;
      end
      chk("R5 reload count restarts on enable", k, 96);

      repeat (4) @(negedge clk);
      summary();
      $finish;
   end
endmodule